// File: doc/BRIEF.md
# Six-Operation Multicycle Processor Core

This block is a minimal programmable core that runs one instruction at a time over several clock cycles. Every instruction is 16 bits wide. Each instruction is fetched from an external instruction memory port and held in an instruction register. It is then decoded and executed against a sixteen-entry register file, a two-function arithmetic unit and an external data memory port. Both memories sit outside the core and answer reads combinationally, within the same cycle. The data memory captures a write on the clock edge that ends a cycle in which the write strobe is high.

The core supports six operations: memory to register, register to memory, add, subtract, load of an 8-bit immediate, and a conditional relative branch taken when a register holds zero. The program counter is already advanced during fetch, so the branch adder compensates for that step. A branch offset therefore counts from the branch instruction itself. Programs end by branching to themselves on a register known to be zero.

Top module: `mc_proc`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, none of `imem_rd`, `dmem_rd` or `dmem_wr` is high. The second cycle after release is a fetch from address 0.
- R2: A fetch raises `imem_rd` for one cycle, captures `imem_data` and adds one to `imem_addr`. The next cycle is a decode cycle with no strobe. Most instructions take three cycles: fetch, decode and execute. Fields are opcode [15:12], register a [11:8], byte [7:0], register b [7:4] and register c [3:0].
- R3: Opcode 0000 writes register a with `dmem_rdata` read at address [7:0], with `dmem_rd` high in the execute cycle. A fetch follows every memory access.
- R4: Opcode 0001 drives `dmem_addr` from [7:0] and `dmem_wdata` from register a, with `dmem_wr` high for exactly one cycle.
- R5: Opcode 0010 writes register a with register b plus register c, modulo 2^DATA_W.
- R6: Opcode 0100 writes register a with register b minus register c, modulo 2^DATA_W.
- R7: Opcode 0011 writes register a with byte [7:0], zero-extended.
- R8: Opcode 0101 tests register a. If it is zero, the next fetch address is the branch's own address plus the sign-extended byte [7:0], and the instruction takes four cycles. Otherwise execution continues in sequence after three cycles.
- R9: Opcodes 0110 through 1111 change no register and touch no memory. They take two cycles: fetch and decode.
- R10: At most one of `imem_rd`, `dmem_rd` and `dmem_wr` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_rd | output | 1 | Instruction read strobe |
| imem_addr | output | PC_W | Instruction address (program counter) |
| imem_data | input | 16 | Instruction word at `imem_addr` |
| dmem_rd | output | 1 | Data read strobe |
| dmem_wr | output | 1 | Data write strobe |
| dmem_addr | output | 8 | Data address |
| dmem_wdata | output | DATA_W | Store data |
| dmem_rdata | input | DATA_W | Load data at `dmem_addr` |

## Verification
The bench builds the core with its defaults: DATA_W of 16 and PC_W of 8. With these widths, a subtract from zero yields 0xFFFF and an add past 0xFFFF wraps to zero, so both carry and borrow edges become observable. An all-ones immediate shows that zero-extension keeps the upper byte clear. Directed programs cover the following:
- forward branches, both taken and not taken, with cycle counts that depend on the data;
- a backward branch that closes a countdown loop;
- self-branch halts;
- undefined opcodes placed between stores.

// File: rtl/mc_proc_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the multicycle core: instruction fields, opcodes,
// controller states, write-select and ALU-select codes, control bundle.
package mc_proc_pkg;

    localparam int INSTR_W = 16;
    localparam int OP_W    = 4;
    localparam int RIDX_W  = 4;
    localparam int BYTE_W  = 8;
    localparam int NREG    = 2 ** RIDX_W;

    localparam logic [OP_W-1:0] OP_LOAD  = 4'h0;
    localparam logic [OP_W-1:0] OP_STORE = 4'h1;
    localparam logic [OP_W-1:0] OP_ADD   = 4'h2;
    localparam logic [OP_W-1:0] OP_LDC   = 4'h3;
    localparam logic [OP_W-1:0] OP_SUB   = 4'h4;
    localparam logic [OP_W-1:0] OP_JZ    = 4'h5;

    localparam logic [1:0] WSEL_ALU = 2'b00;
    localparam logic [1:0] WSEL_MEM = 2'b01;
    localparam logic [1:0] WSEL_IMM = 2'b10;

    localparam logic [1:0] ALU_PASS = 2'b00;
    localparam logic [1:0] ALU_ADD  = 2'b01;
    localparam logic [1:0] ALU_SUB  = 2'b10;

    typedef enum logic [3:0] {
        ST_INIT, ST_FETCH, ST_DECODE, ST_LOAD, ST_STORE,
        ST_ADD, ST_LDC, ST_SUB, ST_JZ, ST_JZ_TAKE
    } state_e;

    typedef struct packed {
        logic       pc_clr;
        logic       pc_inc;
        logic       pc_ld;
        logic       ir_ld;
        logic       imem_rd;
        logic       dmem_rd;
        logic       dmem_wr;
        logic       rf_we;
        logic [1:0] wsel;
        logic       rp_use_b;
        logic [1:0] alu_sel;
    } ctrl_t;

endpackage

// File: rtl/mc_regfile.sv
`timescale 1ns/1ps
// Register file: NREG words of DATA_W bits, two combinational read ports,
// one synchronous write port. Assumes a write and a read of the same entry
// in one cycle returns the old value.
module mc_regfile #(
    parameter int DATA_W = 16,
    parameter int NREG   = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  rp_addr,
    output logic [DATA_W-1:0] rp_data,
    input  logic [IDX_W-1:0]  rq_addr,
    output logic [DATA_W-1:0] rq_data
);

    logic [DATA_W-1:0] regs [NREG];

    // Clear on reset, otherwise write one entry when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    // Read ports are plain multiplexers.
    assign rp_data = regs[rp_addr];
    assign rq_data = regs[rq_addr];

endmodule

// File: rtl/mc_alu.sv
`timescale 1ns/1ps
// Two-function ALU: add or subtract, wrapping modulo 2^DATA_W; any other
// select passes the first operand through.
module mc_alu
    import mc_proc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res
);

    // Select the operation.
    always_comb begin
        case (sel)
            ALU_ADD: res = opa + opb;
            ALU_SUB: res = opa - opb;
            default: res = opa;
        endcase
    end

endmodule

// File: rtl/mc_ctrl.sv
`timescale 1ns/1ps
// Controller FSM: init, fetch, decode, one execute state per opcode, plus
// an extra state for a taken zero-branch. Undefined opcodes return to fetch
// from decode. Assumes rp_zero reflects register a while in ST_JZ.
module mc_ctrl
    import mc_proc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    input  logic            rp_zero,
    output ctrl_t           ctl
);

    state_e state_q, state_d;

    // State register; reset forces the init state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    // Next-state and control decode.
    always_comb begin
        ctl     = '0;
        state_d = state_q;
        case (state_q)
            ST_INIT: begin
                ctl.pc_clr = 1'b1;
                state_d    = ST_FETCH;
            end
            ST_FETCH: begin
                ctl.imem_rd = 1'b1;
                ctl.ir_ld   = 1'b1;
                ctl.pc_inc  = 1'b1;
                state_d     = ST_DECODE;
            end
            ST_DECODE: begin
                case (opcode)
                    OP_LOAD:  state_d = ST_LOAD;
                    OP_STORE: state_d = ST_STORE;
                    OP_ADD:   state_d = ST_ADD;
                    OP_LDC:   state_d = ST_LDC;
                    OP_SUB:   state_d = ST_SUB;
                    OP_JZ:    state_d = ST_JZ;
                    default:  state_d = ST_FETCH;
                endcase
            end
            ST_LOAD: begin
                ctl.dmem_rd = 1'b1;
                ctl.rf_we   = 1'b1;
                ctl.wsel    = WSEL_MEM;
                state_d     = ST_FETCH;
            end
            ST_STORE: begin
                ctl.dmem_wr = 1'b1;
                state_d     = ST_FETCH;
            end
            ST_ADD: begin
                ctl.rp_use_b = 1'b1;
                ctl.alu_sel  = ALU_ADD;
                ctl.rf_we    = 1'b1;
                ctl.wsel     = WSEL_ALU;
                state_d      = ST_FETCH;
            end
            ST_SUB: begin
                ctl.rp_use_b = 1'b1;
                ctl.alu_sel  = ALU_SUB;
                ctl.rf_we    = 1'b1;
                ctl.wsel     = WSEL_ALU;
                state_d      = ST_FETCH;
            end
            ST_LDC: begin
                ctl.rf_we = 1'b1;
                ctl.wsel  = WSEL_IMM;
                state_d   = ST_FETCH;
            end
            ST_JZ: begin
                state_d = rp_zero ? ST_JZ_TAKE : ST_FETCH;
            end
            ST_JZ_TAKE: begin
                ctl.pc_ld = 1'b1;
                state_d   = ST_FETCH;
            end
            default: state_d = ST_INIT;
        endcase
    end

endmodule

// File: rtl/mc_proc.sv
`timescale 1ns/1ps
// Multicycle core top: program counter, instruction register, register-file
// write multiplexer, zero detector and relative-branch adder around the
// controller, ALU and register file. Assumes both memories answer reads
// combinationally and that PC_W >= 8 and DATA_W >= 8.
module mc_proc
    import mc_proc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PC_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               imem_rd,
    output logic [PC_W-1:0]    imem_addr,
    input  logic [INSTR_W-1:0] imem_data,
    output logic               dmem_rd,
    output logic               dmem_wr,
    output logic [BYTE_W-1:0]  dmem_addr,
    output logic [DATA_W-1:0]  dmem_wdata,
    input  logic [DATA_W-1:0]  dmem_rdata
);

    ctrl_t              ctl;
    logic [PC_W-1:0]    pc_q;
    logic [PC_W-1:0]    br_target;
    logic [INSTR_W-1:0] ir_q;
    logic [RIDX_W-1:0]  fld_a, fld_b, fld_c, rp_addr;
    logic [BYTE_W-1:0]  fld_byte;
    logic [DATA_W-1:0]  rp_data, rq_data, alu_res, rf_wdata;
    logic               rp_zero;

    assign fld_a    = ir_q[11:8];
    assign fld_b    = ir_q[7:4];
    assign fld_c    = ir_q[3:0];
    assign fld_byte = ir_q[7:0];

    // Fetch already advanced the PC, so the branch target drops one.
    assign br_target = pc_q + PC_W'($signed(fld_byte)) - PC_W'(1);

    // Program counter: clear, branch load, or increment.
    always_ff @(posedge clk) begin
        if (!rst_n)          pc_q <= '0;
        else if (ctl.pc_clr) pc_q <= '0;
        else if (ctl.pc_ld)  pc_q <= br_target;
        else if (ctl.pc_inc) pc_q <= pc_q + PC_W'(1);
    end

    // Instruction register, loaded during fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)         ir_q <= '0;
        else if (ctl.ir_ld) ir_q <= imem_data;
    end

    // Read port Rp carries register b for arithmetic, register a otherwise.
    assign rp_addr = ctl.rp_use_b ? fld_b : fld_a;

    // Register-file write source: ALU, memory or zero-extended immediate.
    always_comb begin
        case (ctl.wsel)
            WSEL_MEM: rf_wdata = dmem_rdata;
            WSEL_IMM: rf_wdata = DATA_W'(fld_byte);
            default:  rf_wdata = alu_res;
        endcase
    end

    assign rp_zero = ~|rp_data;

    mc_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .opcode  (ir_q[15:12]),
        .rp_zero (rp_zero),
        .ctl     (ctl)
    );

    mc_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ctl.rf_we),
        .waddr   (fld_a),
        .wdata   (rf_wdata),
        .rp_addr (rp_addr),
        .rp_data (rp_data),
        .rq_addr (fld_c),
        .rq_data (rq_data)
    );

    mc_alu #(.DATA_W(DATA_W)) u_alu (
        .sel (ctl.alu_sel),
        .opa (rp_data),
        .opb (rq_data),
        .res (alu_res)
    );

    assign imem_rd    = ctl.imem_rd;
    assign imem_addr  = pc_q;
    assign dmem_rd    = ctl.dmem_rd;
    assign dmem_wr    = ctl.dmem_wr;
    assign dmem_addr  = fld_byte;
    assign dmem_wdata = rp_data;

endmodule

// File: rtl/mc_proc_chk.sv
`timescale 1ns/1ps
// Port-level protocol checker for mc_proc, attached by bind below.
module mc_proc_chk #(
    parameter int PC_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            imem_rd,
    input logic            dmem_rd,
    input logic            dmem_wr,
    input logic [PC_W-1:0] imem_addr
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!imem_rd && !dmem_rd && !dmem_wr)); // R1

    AST_FETCH_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        imem_rd |=> (imem_addr == $past(imem_addr) + PC_W'(1))); // R2

    AST_DECODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        imem_rd |=> (!imem_rd && !dmem_rd && !dmem_wr)); // R2

    AST_LOAD_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_rd || dmem_wr) |=> imem_rd); // R3

    AST_STORE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_wr |=> !dmem_wr); // R4

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({imem_rd, dmem_rd, dmem_wr})); // R10

endmodule

bind mc_proc mc_proc_chk #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_rd   (imem_rd),
    .dmem_rd   (dmem_rd),
    .dmem_wr   (dmem_wr),
    .imem_addr (imem_addr)
);

// File: tb/mc_proc_bench.sv
`timescale 1ns/1ps
// Directed bench: each task loads a program, runs it and checks memory,
// strobe behaviour and store timing.
module mc_proc_bench;

    localparam int DW = 16;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          imem_rd, dmem_rd, dmem_wr;
    logic [PW-1:0] imem_addr;
    logic [15:0]   imem_data;
    logic [7:0]    dmem_addr;
    logic [DW-1:0] dmem_wdata, dmem_rdata;

    logic [15:0]   imem [256];
    logic [DW-1:0] dmem [256];

    int tests = 0;
    int fails = 0;
    int first_wr, wr_cnt, multi;

    always #2.5 clk = ~clk;

    mc_proc #(.DATA_W(DW), .PC_W(PW)) u_mc_proc (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_rd    (imem_rd),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_rd    (dmem_rd),
        .dmem_wr    (dmem_wr),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_data  = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_addr];

    always @(posedge clk) begin
        if (dmem_wr) dmem[dmem_addr] <= dmem_wdata;
    end

    function automatic logic [15:0] i_ld(int a, int d);   return {4'h0, 4'(a), 8'(d)}; endfunction
    function automatic logic [15:0] i_st(int a, int d);   return {4'h1, 4'(a), 8'(d)}; endfunction
    function automatic logic [15:0] i_add(int a, int b, int c); return {4'h2, 4'(a), 4'(b), 4'(c)}; endfunction
    function automatic logic [15:0] i_ldc(int a, int k);  return {4'h3, 4'(a), 8'(k)}; endfunction
    function automatic logic [15:0] i_sub(int a, int b, int c); return {4'h4, 4'(a), 4'(b), 4'(c)}; endfunction
    function automatic logic [15:0] i_jz(int a, int off); return {4'h5, 4'(a), 8'(off)}; endfunction

    task automatic check_eq(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            imem[i] = 16'h0000;
            dmem[i] = '0;
        end
    endtask

    // Reset, release, then run ncyc cycles logging strobes at negedges.
    task automatic run_prog(int ncyc);
        first_wr = -1;
        wr_cnt   = 0;
        multi    = 0;
        rst_n    = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R1 strobes in reset", int'({imem_rd, dmem_rd, dmem_wr}), 0);
        rst_n = 1'b1;
        for (int cyc = 1; cyc <= ncyc; cyc++) begin
            @(negedge clk);
            if (cyc == 1) begin
                check_eq("R1 first fetch strobe", int'(imem_rd), 1);
                check_eq("R1 first fetch addr", int'(imem_addr), 0);
            end
            if (dmem_wr) begin
                wr_cnt++;
                if (first_wr < 0) first_wr = cyc;
            end
            if (int'(imem_rd) + int'(dmem_rd) + int'(dmem_wr) > 1) multi++;
        end
    endtask

    // D[9] = D[0] + D[1]
    task automatic t_sum(int x, int y);
        clear_mem();
        dmem[0] = DW'(x);
        dmem[1] = DW'(y);
        imem[0] = i_ld(0, 0);
        imem[1] = i_ld(1, 1);
        imem[2] = i_add(2, 0, 1);
        imem[3] = i_st(2, 9);
        imem[4] = i_ldc(15, 0);
        imem[5] = i_jz(15, 0);
        run_prog(40);
        check_eq("R3 R5 sum stored", int'(dmem[9]), (x + y) & 16'hFFFF);
        check_eq("R2 store cycle", first_wr, 12);
        check_eq("R4 single store", wr_cnt, 1);
        check_eq("R10 one strobe", multi, 0);
    endtask

    // D[9] = number of non-zero words among D[4], D[5]
    task automatic t_count(int x, int y);
        int nz, k, taken;
        clear_mem();
        dmem[4] = DW'(x);
        dmem[5] = DW'(y);
        dmem[9] = 16'hBEEF;
        imem[0]  = i_ldc(0, 0);
        imem[1]  = i_ldc(1, 1);
        imem[2]  = i_ld(2, 4);
        imem[3]  = i_jz(2, 2);
        imem[4]  = i_add(0, 0, 1);
        imem[5]  = i_ld(2, 5);
        imem[6]  = i_jz(2, 2);
        imem[7]  = i_add(0, 0, 1);
        imem[8]  = i_st(0, 9);
        imem[9]  = i_ldc(15, 0);
        imem[10] = i_jz(15, 0);
        run_prog(60);
        nz    = int'(x != 0) + int'(y != 0);
        taken = 2 - nz;
        k     = 6 + nz;
        check_eq("R8 count value", int'(dmem[9]), nz);
        check_eq("R8 store cycle", first_wr, 3 + 3 * k + taken);
        check_eq("R8 single store", wr_cnt, 1);
    endtask

    // Countdown loop closed by a backward branch: 3+2+1 into D[20]
    task automatic t_loop();
        clear_mem();
        imem[0] = i_ldc(15, 0);
        imem[1] = i_ldc(1, 1);
        imem[2] = i_ldc(2, 3);
        imem[3] = i_ldc(3, 0);
        imem[4] = i_add(3, 3, 2);
        imem[5] = i_sub(2, 2, 1);
        imem[6] = i_jz(2, 2);
        imem[7] = i_jz(15, -3);
        imem[8] = i_st(3, 20);
        imem[9] = i_jz(15, 0);
        run_prog(120);
        check_eq("R6 R8 loop sum", int'(dmem[20]), 6);
        check_eq("R8 loop single store", wr_cnt, 1);
    endtask

    // Immediate extension, wrap-around and undefined opcodes
    task automatic t_misc();
        clear_mem();
        dmem[32] = 16'h1234;
        imem[0]  = i_ldc(5, 255);
        imem[1]  = i_ldc(6, 0);
        imem[2]  = i_ldc(7, 1);
        imem[3]  = i_sub(8, 6, 7);
        imem[4]  = i_add(9, 8, 7);
        imem[5]  = 16'h6599;
        imem[6]  = 16'hF5FF;
        imem[7]  = i_st(5, 30);
        imem[8]  = i_st(8, 31);
        imem[9]  = i_st(9, 32);
        imem[10] = i_ldc(15, 0);
        imem[11] = i_jz(15, 0);
        run_prog(60);
        check_eq("R7 zero-extended immediate", int'(dmem[30]), 16'h00FF);
        check_eq("R6 borrow wrap", int'(dmem[31]), 16'hFFFF);
        check_eq("R5 carry wrap", int'(dmem[32]), 0);
        check_eq("R9 no-op timing", first_wr, 22);
        check_eq("R9 no extra access", wr_cnt, 3);
        check_eq("R10 one strobe misc", multi, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_sum(99, 102);
        t_sum(16'hFFFF, 2);
        t_count(7, 9);
        t_count(7, 0);
        t_count(0, 5);
        t_count(0, 0);
        t_loop();
        t_misc();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule